// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits on the bus side of a processor and keeps a small stock of instruction bytes ready for the execution side. It reads memory one 16-bit word at a time. It starts a new read only when the ring has at least two free byte slots. The execution side removes bytes one at a time, so reads from memory overlap with execution.

A redirect (jump) input empties the ring and moves the fetch pointer to a new 20-bit target. The target may be odd. In that case the first word read after the redirect contributes only its upper byte. If a read is already in flight when a redirect arrives, its data is thrown away when it comes back.

The memory port is a level request held until an acknowledge returns the word. Bytes leave through a pop port with a valid flag.

Top module: `prefetch_byte_queue`

## Requirements
- R1: While reset is high, mem_req and pop_valid are low. The first request after reset reads address BOOT_ADDR with bit 0 cleared.
- R2: A new request starts only when the occupancy is at most DEPTH-2. The occupancy never exceeds DEPTH. A full ring keeps mem_req low.
- R3: Once raised, mem_req stays high with mem_addr unchanged until a cycle with mem_ack high. Bit 0 of mem_addr is always 0.
- R4: A returned word supplies its even-address byte from mem_rdata[7:0] ahead of its odd-address byte from mem_rdata[15:8]. pop_data always shows the byte at the next sequential address.
- R5: After each accepted fetch, the next request address is the previous one plus 2, wrapping modulo 2^ADDR_W.
- R6: A cycle with flush_en high discards every queued byte, and pop_valid is low in the following cycle. A pop in the same cycle as flush_en is ignored. The next byte popped is the byte at flush_addr.
- R7: For an odd flush_addr, the first request is for flush_addr-1, and only mem_rdata[15:8] of that word enters the ring.
- R8: A word whose request was outstanding when flush_en was high is discarded. This includes a word acknowledged in the same cycle as flush_en.
- R9: A pop and an enqueue may occur in the same cycle, and the occupancy changes by their net amount. pop_valid is high exactly when the occupancy is nonzero.
- R10: pop_en while pop_valid is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Word read request, held until acknowledged |
| mem_addr | output | ADDR_W | Even byte address of the requested word |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 16 | Returned word, even-address byte in bits 7:0 |
| pop_en | input | 1 | Execution side takes the head byte |
| pop_valid | output | 1 | Head byte is present |
| pop_data | output | 8 | Head byte |
| flush_en | input | 1 | Redirect: empty the ring and restart fetching |
| flush_addr | input | ADDR_W | Byte address of the redirect target |

## Verification
The bench builds the block with DEPTH=6, ADDR_W=20 and BOOT_ADDR=0x00010. The nonzero boot address makes the first-request check of R1 distinguishable from a plain zero reset. The 20-bit width lets a redirect near 0xFFFFD carry fetching across the top of the address space and back to zero. A memory latency of zero to five cycles lets redirects land while a read is outstanding, including in the very cycle it is acknowledged. With six slots, an odd target fills the ring to five bytes and stalls fetching until one pop frees room.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_BITS  = 8;
    localparam int WORD_BYTES = 2;
    localparam int WORD_BITS  = BYTE_BITS * WORD_BYTES;

    typedef enum logic [0:0] {
        FETCH_IDLE = 1'b0,
        FETCH_BUSY = 1'b1
    } fetch_state_e;

    // Bytes handed from the fetch side to the ring in one cycle.
    // n = 0, 1 or 2; first is written before second.
    typedef struct packed {
        logic [1:0]           n;
        logic [BYTE_BITS-1:0] first;
        logic [BYTE_BITS-1:0] second;
    } enq_bundle_t;

    function automatic int ring_step(input int pos, input int amount, input int depth);
        int s;
        s = pos + amount;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int                DEPTH     = 6,
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
    localparam int               CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_req,
    input  logic [ADDR_W-1:0]    flush_target,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata,
    input  logic [CNT_W-1:0]     fill_level,
    output enq_bundle_t          enq
);

    localparam logic [CNT_W-1:0]  ISSUE_MAX = CNT_W'(DEPTH - WORD_BYTES);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

    fetch_state_e      state_q;
    logic [ADDR_W-1:0] next_fetch_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              odd_entry_q;
    logic              stale_q;
    logic              accept;
    logic              fresh;

    assign accept   = (state_q == FETCH_BUSY) && mem_ack;
    assign fresh    = accept && !stale_q && !flush_req;
    assign mem_req  = (state_q == FETCH_BUSY);
    assign mem_addr = req_addr_q;

    always_comb begin
        enq = '0;
        if (fresh) begin
            if (odd_entry_q) begin
                enq.n     = 2'd1;
                enq.first = mem_rdata[WORD_BITS-1:BYTE_BITS];
            end else begin
                enq.n      = 2'd2;
                enq.first  = mem_rdata[BYTE_BITS-1:0];
                enq.second = mem_rdata[WORD_BITS-1:BYTE_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= FETCH_IDLE;
            next_fetch_q <= {BOOT_ADDR[ADDR_W-1:1], 1'b0};
            odd_entry_q  <= BOOT_ADDR[0];
            stale_q      <= 1'b0;
            req_addr_q   <= '0;
        end else begin
            case (state_q)
                FETCH_IDLE: begin
                    if (!flush_req && fill_level <= ISSUE_MAX) begin
                        state_q    <= FETCH_BUSY;
                        req_addr_q <= next_fetch_q;
                    end
                end
                default: begin
                    if (mem_ack) begin
                        state_q <= FETCH_IDLE;
                        stale_q <= 1'b0;
                    end else if (flush_req) begin
                        stale_q <= 1'b1;
                    end
                end
            endcase

            if (flush_req) begin
                next_fetch_q <= {flush_target[ADDR_W-1:1], 1'b0};
                odd_entry_q  <= flush_target[0];
            end else if (fresh) begin
                next_fetch_q <= next_fetch_q + ADDR_STEP;
                odd_entry_q  <= 1'b0;
            end
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_addr_even_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[0] == 1'b0));

    assert_issue_room_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(fill_level) <= ISSUE_MAX));

    assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
        fresh |=> (next_fetch_q == $past(next_fetch_q) + ADDR_STEP));

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int  DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  enq_bundle_t          enq,
    input  logic                 pop_req,
    output logic                 pop_valid,
    output logic [BYTE_BITS-1:0] pop_byte,
    output logic [CNT_W-1:0]     fill_level
);

    logic [DEPTH-1:0][BYTE_BITS-1:0] slot_view;
    logic [PTR_W-1:0]                head_q;
    logic [PTR_W-1:0]                tail_q;
    logic [PTR_W-1:0]                tail_nx;
    logic [CNT_W-1:0]                fill_q;
    logic [CNT_W-1:0]                fill_d;
    logic                            take;

    assign pop_valid  = (fill_q != '0);
    assign take       = pop_req && pop_valid && !flush;
    assign pop_byte   = slot_view[head_q];
    assign fill_level = fill_q;
    assign tail_nx    = PTR_W'(ring_step(32'(tail_q), 1, DEPTH));

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [BYTE_BITS-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (enq.n != 2'd0 && tail_q == PTR_W'(gi)) begin
                cell_q <= enq.first;
            end else if (enq.n == 2'd2 && tail_nx == PTR_W'(gi)) begin
                cell_q <= enq.second;
            end
        end
        assign slot_view[gi] = cell_q;
    end

    always_comb begin
        fill_d = fill_q + CNT_W'(enq.n) - CNT_W'(take);
        if (flush) fill_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
            if (take) head_q <= PTR_W'(ring_step(32'(head_q), 1, DEPTH));
            tail_q <= PTR_W'(ring_step(32'(tail_q), 32'(enq.n), DEPTH));
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CNT_W'(DEPTH));

    assert_idle_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (!pop_valid && enq.n == 2'd0) |=> !pop_valid);

endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
    import pfq_pkg::*;
#(
    parameter int                DEPTH     = 6,
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic [WORD_BITS-1:0] mem_rdata,
    input  logic                 pop_en,
    output logic                 pop_valid,
    output logic [BYTE_BITS-1:0] pop_data,
    input  logic                 flush_en,
    input  logic [ADDR_W-1:0]    flush_addr
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fill_level;
    enq_bundle_t      enq;

    pfq_fetch_ctrl #(
        .DEPTH     (DEPTH),
        .ADDR_W    (ADDR_W),
        .BOOT_ADDR (BOOT_ADDR)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .flush_req    (flush_en),
        .flush_target (flush_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .fill_level   (fill_level),
        .enq          (enq)
    );

    pfq_byte_ring #(
        .DEPTH (DEPTH)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_en),
        .enq        (enq),
        .pop_req    (pop_en),
        .pop_valid  (pop_valid),
        .pop_byte   (pop_data),
        .fill_level (fill_level)
    );

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
        flush_en |=> !pop_valid);

    assert_stale_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && flush_en) |=> !pop_valid);

endmodule

// File: tb/prefetch_byte_queue_tb_top.sv
module prefetch_byte_queue_tb_top;

    localparam int             DEPTH = 6;
    localparam int             AW    = 20;
    localparam logic [AW-1:0]  BOOT  = 20'h00010;

    logic          clk = 1'b0;
    logic          rst;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [15:0]   mem_rdata;
    logic          pop_en;
    logic          pop_valid;
    logic [7:0]    pop_data;
    logic          flush_en;
    logic [AW-1:0] flush_addr;

    always #10 clk = ~clk;

    prefetch_byte_queue #(
        .DEPTH     (DEPTH),
        .ADDR_W    (AW),
        .BOOT_ADDR (BOOT)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .pop_en     (pop_en),
        .pop_valid  (pop_valid),
        .pop_data   (pop_data),
        .flush_en   (flush_en),
        .flush_addr (flush_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    int            occ;
    logic [AW-1:0] exp_pop, exp_fetch, held_addr, hook_tgt;
    bit            skip, stale, outstanding, first_req, odd_first;
    bit            chk_r6, chk_r8, chk_r10, hook_flush;
    int            lat_cnt, lat_lo, lat_hi, pop_pct, flush_pct;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cycle_once(input bit force_flush, input logic [AW-1:0] tgt);
        bit            pv, mr, ack, pop, fl, newreq;
        logic [7:0]    pd;
        logic [AW-1:0] ma, t;
        @(negedge clk);
        pv = pop_valid; pd = pop_data; mr = mem_req; ma = mem_addr;
        if (chk_r6)  check(pv == 1'b0, "R6", "pop_valid after flush", int'(pv), 0);
        if (chk_r8)  check(pv == 1'b0, "R8", "pop_valid after dropped word", int'(pv), 0);
        if (chk_r10) check(pv == (occ != 0), "R10", "state after pop on empty", int'(pv), int'(occ != 0));
        chk_r6 = 0; chk_r8 = 0; chk_r10 = 0;
        check(pv == (occ != 0), "R9", "pop_valid vs occupancy", int'(pv), int'(occ != 0));
        newreq = mr && !outstanding;
        if (newreq) begin
            check(ma == exp_fetch, first_req ? "R1" : "R5", "request address", int'(ma), int'(exp_fetch));
            check(ma[0] == 1'b0, "R3", "request address even", int'(ma[0]), 0);
            check(occ <= DEPTH - 2, "R2", "occupancy at issue", occ, DEPTH - 2);
            held_addr = ma;
            first_req = 0;
            lat_cnt = lat_lo + int'($urandom_range(lat_hi - lat_lo));
        end else if (mr) begin
            check(ma == held_addr, "R3", "address held", int'(ma), int'(held_addr));
        end
        if (pv) check(pd == mem_byte(exp_pop), odd_first ? "R7" : "R4", "pop_data",
                      int'(pd), int'(mem_byte(exp_pop)));
        ack = 0;
        if (mr) begin
            if (lat_cnt == 0) ack = 1;
            else lat_cnt--;
        end
        fl = force_flush || ($urandom_range(99) < flush_pct);
        t  = force_flush ? tgt : AW'($urandom);
        if (hook_flush && newreq) begin
            fl = 1; t = hook_tgt; hook_flush = 0;
        end
        pop = ($urandom_range(99) < pop_pct);
        mem_ack    = ack;
        mem_rdata  = ack ? {mem_byte(ma + 1'b1), mem_byte(ma)} : 16'h0;
        pop_en     = pop;
        flush_en   = fl;
        flush_addr = t;
        // expected state after the coming edge
        if (pop && !pv) chk_r10 = 1;
        if (pop && pv && !fl) begin
            exp_pop = exp_pop + 1'b1;
            occ--;
            odd_first = 0;
        end
        if (ack) begin
            if (!stale && !fl) begin
                occ += skip ? 1 : 2;
                exp_fetch = exp_fetch + AW'(2);
                skip = 0;
            end else begin
                chk_r8 = 1;
            end
            stale = 0;
            outstanding = 0;
        end else begin
            outstanding = mr;
            if (mr && fl) stale = 1;
        end
        if (fl) begin
            occ = 0;
            exp_pop = t;
            exp_fetch = {t[AW-1:1], 1'b0};
            skip = t[0];
            odd_first = t[0];
            chk_r6 = 1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; mem_ack = 0; mem_rdata = 0; pop_en = 0; flush_en = 0; flush_addr = 0;
        occ = 0; exp_pop = BOOT; exp_fetch = {BOOT[AW-1:1], 1'b0}; skip = BOOT[0];
        stale = 0; outstanding = 0; first_req = 1; odd_first = 0;
        chk_r6 = 0; chk_r8 = 0; chk_r10 = 0; hook_flush = 0; hook_tgt = '0;
        lat_cnt = 0; lat_lo = 0; lat_hi = 2; pop_pct = 0; flush_pct = 0;
        repeat (3) begin
            @(negedge clk);
            check(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
            check(pop_valid == 1'b0, "R1", "pop_valid in reset", int'(pop_valid), 0);
        end
        rst = 1'b0;

        // fill without pops: ring reaches DEPTH and fetching stops
        repeat (40) cycle_once(0, '0);
        check(occ == DEPTH, "R2", "model occupancy when full", occ, DEPTH);
        check(mem_req == 1'b0, "R2", "request while full", int'(mem_req), 0);
        check(pop_valid == 1'b1, "R9", "pop_valid when full", int'(pop_valid), 1);
        pop_pct = 100;
        repeat (20) cycle_once(0, '0);

        // odd target, then drain
        pop_pct = 0;
        cycle_once(1, 20'h12345);
        repeat (30) cycle_once(0, '0);
        check(occ == DEPTH - 1, "R7", "odd target fill", occ, DEPTH - 1);
        check(mem_req == 1'b0, "R2", "one free slot keeps idle", int'(mem_req), 0);
        pop_pct = 100;
        repeat (20) cycle_once(0, '0);

        // redirect while a slow read is outstanding
        lat_lo = 5; lat_hi = 5; pop_pct = 30;
        cycle_once(1, 20'h00100);
        hook_flush = 1; hook_tgt = 20'h00201;
        repeat (40) cycle_once(0, '0);

        // redirect in the same cycle as the acknowledge
        lat_lo = 0; lat_hi = 0;
        cycle_once(1, 20'h00400);
        hook_flush = 1; hook_tgt = 20'h00800;
        repeat (30) cycle_once(0, '0);

        // wrap across the top of the address space
        lat_lo = 0; lat_hi = 2; pop_pct = 60;
        cycle_once(1, 20'hFFFFD);
        repeat (40) cycle_once(0, '0);

        // random mixes
        lat_lo = 0; lat_hi = 3; pop_pct = 50; flush_pct = 3;
        repeat (15000) cycle_once(0, '0);
        pop_pct = 90; flush_pct = 1;
        repeat (5000) cycle_once(0, '0);
        lat_hi = 5; pop_pct = 20; flush_pct = 4;
        repeat (3000) cycle_once(0, '0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule